// File: doc/BRIEF.md
# Selectable Divider Configuration Bank

This block keeps a small bank of frequency-synthesizer divider settings. Every slot in the bank carries a complete divider word made of four fields: a pre-divider, the integer part of the feedback divider, the fractional part of the feedback divider, and a post-divider. A pair of slow, asynchronous select pins chooses which slot drives the live divider outputs. When the select changes, the live word switches to the newly chosen slot as soon as the select has crossed its synchronizer. There is no other staging.

Reset loads every slot with a default word. The defaults are module parameters. A field-addressed host port sits behind a serial-bus bridge. Through it the host stages new field values for any slot, commits the staged fields of that slot in a single write, and reads back the committed fields of any slot, including the one that is live. Because all four fields are committed together, a slot being rewritten never drives a half-updated divider word.

Top module: `divcfg_bank`

## Requirements
- R1: Field widths are pre-divider 2 bits, integer feedback 7 bits, fractional feedback 18 bits and post-divider 7 bits. A field write takes the low bits of `host_wdata` for that field width and ignores the upper bits.
- R2: The live outputs `div_pre`, `div_mint`, `div_frac` and `div_post` show the committed word of the slot whose index equals the synchronized select value: binary 0, 1, 2 or 3. `sel_live` reports that index.
- R3: After reset, every slot and its staging fields hold that slot's default word, `sel_live` is 0 and `host_rdata` is 0. Values written before the reset are lost.
- R4: A field write (field codes 0 to 3) changes only the staging copy of its slot. The committed value, its readback and the live outputs stay unchanged until a write with field code 4 (commit) copies all four staged fields of that slot at once. The live outputs show the new word right after the clock edge that takes the commit.
- R5: A change on `sel_pins` reaches `sel_live` and the live outputs after exactly two rising clock edges, and not before.
- R6: `host_addr` is {slot index, 3-bit field code}, with the field code in bits [2:0]. Reading field codes 0 to 3 returns the committed field, zero-extended, on `host_rdata` one clock edge after the address is presented. Any slot can be read, including the live one.
- R7: Field codes 5, 6 and 7 are reserved. Writes to them change nothing, and reading them returns 0. Reading field code 4 also returns 0.
- R8: Staging fields keep their last written value, or the default after reset. A commit therefore installs any field that was not rewritten with its staged value, and a commit with no field writes since reset reinstalls the default.
- R9: Writes and commits addressed to one slot never change another slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads the defaults |
| sel_pins | input | 2 | Asynchronous slot select |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | {slot index, field code} |
| host_wdata | input | 18 | Host write data, low bits used per field |
| host_rdata | output | 18 | Registered readback of the addressed field |
| div_pre | output | 2 | Live pre-divider |
| div_mint | output | 7 | Live integer feedback value |
| div_frac | output | 18 | Live fractional feedback value |
| div_post | output | 7 | Live post-divider |
| sel_live | output | 2 | Synchronized slot index in use |

## Verification
Each result has a fixed latency. A select change shows on the live outputs after the second rising edge. A committed word shows after the edge that takes the commit. Readback data shows after the edge following the address. The bench drives every input on a falling edge and compares on the falling edge at which the result is due. For a select change it also compares one falling edge earlier, to confirm that the old word is still present. During field writes it compares the live word and the readback after every write, to confirm that neither moves before the commit.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;

   localparam int unsigned FCODE_W = 3;

   typedef enum logic [FCODE_W-1:0] {
      FC_PRE    = 3'd0,
      FC_MINT   = 3'd1,
      FC_FRAC   = 3'd2,
      FC_POST   = 3'd3,
      FC_COMMIT = 3'd4
   } fcode_e;

   function automatic int unsigned wmax4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   if (W < 1) begin : g_bad_w
      $error("divcfg_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("divcfg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d_async;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_sync = chain[STAGES-1];

   if (STAGES == 2) begin : g_chk_two
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              warm <= 2'd0;
         else if (warm != 2'd3)   warm <= warm + 2'd1;
      end
      // R5: output follows the asynchronous input after two edges
      a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd3) |-> (q_sync == $past(d_async, 2)));
   end

endmodule

// File: rtl/divcfg_slot.sv
module divcfg_slot #(
   parameter int PRE_W  = 2,
   parameter int MINT_W = 7,
   parameter int FRAC_W = 18,
   parameter int POST_W = 7,
   parameter int DATA_W = 18,
   parameter int WORD_W = PRE_W + MINT_W + FRAC_W + POST_W,
   parameter logic [WORD_W-1:0] DEF = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [divcfg_pkg::FCODE_W-1:0]    wr_code,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [WORD_W-1:0]                 word_q
);
   import divcfg_pkg::*;

   localparam int POST_LSB = 0;
   localparam int FRAC_LSB = POST_LSB + POST_W;
   localparam int MINT_LSB = FRAC_LSB + FRAC_W;
   localparam int PRE_LSB  = MINT_LSB + MINT_W;

   if (WORD_W != PRE_W + MINT_W + FRAC_W + POST_W) begin : g_bad_word
      $error("divcfg_slot: WORD_W does not match the field widths");
   end
   if (DATA_W < wmax4(PRE_W, MINT_W, FRAC_W, POST_W)) begin : g_bad_data
      $error("divcfg_slot: DATA_W narrower than a field");
   end

   logic [PRE_W-1:0]  st_pre;
   logic [MINT_W-1:0] st_mint;
   logic [FRAC_W-1:0] st_frac;
   logic [POST_W-1:0] st_post;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_pre  <= DEF[PRE_LSB  +: PRE_W];
         st_mint <= DEF[MINT_LSB +: MINT_W];
         st_frac <= DEF[FRAC_LSB +: FRAC_W];
         st_post <= DEF[POST_LSB +: POST_W];
         word_q  <= DEF;
      end else if (wr_en) begin
         case (wr_code)
            FC_PRE:    st_pre  <= wr_data[PRE_W-1:0];
            FC_MINT:   st_mint <= wr_data[MINT_W-1:0];
            FC_FRAC:   st_frac <= wr_data[FRAC_W-1:0];
            FC_POST:   st_post <= wr_data[POST_W-1:0];
            FC_COMMIT: word_q  <= {st_pre, st_mint, st_frac, st_post};
            default:   ;
         endcase
      end
   end

   // R4: committed word moves only after a commit write
   a_r4_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && (wr_code == FC_COMMIT)) |-> $stable(word_q));

endmodule

// File: rtl/divcfg_bank.sv
module divcfg_bank #(
   parameter int NSLOT       = 4,
   parameter int PRE_W       = 2,
   parameter int MINT_W      = 7,
   parameter int FRAC_W      = 18,
   parameter int POST_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter logic [NSLOT*(PRE_W+MINT_W+FRAC_W+POST_W)-1:0] DEFAULTS = '0
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [$clog2(NSLOT)-1:0]                 sel_pins,
   input  logic                                     host_we,
   input  logic [$clog2(NSLOT)+divcfg_pkg::FCODE_W-1:0] host_addr,
   input  logic [divcfg_pkg::wmax4(PRE_W, MINT_W, FRAC_W, POST_W)-1:0] host_wdata,
   output logic [divcfg_pkg::wmax4(PRE_W, MINT_W, FRAC_W, POST_W)-1:0] host_rdata,
   output logic [PRE_W-1:0]                         div_pre,
   output logic [MINT_W-1:0]                        div_mint,
   output logic [FRAC_W-1:0]                        div_frac,
   output logic [POST_W-1:0]                        div_post,
   output logic [$clog2(NSLOT)-1:0]                 sel_live
);
   import divcfg_pkg::*;

   localparam int SLOT_AW  = $clog2(NSLOT);
   localparam int WORD_W   = PRE_W + MINT_W + FRAC_W + POST_W;
   localparam int DATA_W   = wmax4(PRE_W, MINT_W, FRAC_W, POST_W);
   localparam int POST_LSB = 0;
   localparam int FRAC_LSB = POST_LSB + POST_W;
   localparam int MINT_LSB = FRAC_LSB + FRAC_W;
   localparam int PRE_LSB  = MINT_LSB + MINT_W;

   if (NSLOT < 2 || (1 << SLOT_AW) != NSLOT) begin : g_bad_nslot
      $error("divcfg_bank: NSLOT must be a power of two, at least 2");
   end
   if (PRE_W < 1 || MINT_W < 1 || FRAC_W < 1 || POST_W < 1) begin : g_bad_fields
      $error("divcfg_bank: every field needs at least one bit");
   end

   logic [FCODE_W-1:0] a_code;
   logic [SLOT_AW-1:0] a_slot;
   assign a_code = host_addr[FCODE_W-1:0];
   assign a_slot = host_addr[FCODE_W +: SLOT_AW];

   // select synchronizer
   logic [SLOT_AW-1:0] sel_sync;
   divcfg_sync #(.W(SLOT_AW), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sel_pins),
      .q_sync  (sel_sync)
   );

   // slot storage
   logic [WORD_W-1:0] slot_word [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic wr_hit;
      assign wr_hit = host_we && (a_slot == SLOT_AW'(g));
      divcfg_slot #(
         .PRE_W  (PRE_W),
         .MINT_W (MINT_W),
         .FRAC_W (FRAC_W),
         .POST_W (POST_W),
         .DATA_W (DATA_W),
         .WORD_W (WORD_W),
         .DEF    (DEFAULTS[g*WORD_W +: WORD_W])
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_hit),
         .wr_code (a_code),
         .wr_data (host_wdata),
         .word_q  (slot_word[g])
      );
   end

   // live selection
   logic [WORD_W-1:0] live_word;
   assign live_word = slot_word[sel_sync];
   assign div_pre   = live_word[PRE_LSB  +: PRE_W];
   assign div_mint  = live_word[MINT_LSB +: MINT_W];
   assign div_frac  = live_word[FRAC_LSB +: FRAC_W];
   assign div_post  = live_word[POST_LSB +: POST_W];
   assign sel_live  = sel_sync;

   // readback
   logic [WORD_W-1:0] rd_word;
   assign rd_word = slot_word[a_slot];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else begin
         case (a_code)
            FC_PRE:  host_rdata <= DATA_W'(rd_word[PRE_LSB  +: PRE_W]);
            FC_MINT: host_rdata <= DATA_W'(rd_word[MINT_LSB +: MINT_W]);
            FC_FRAC: host_rdata <= DATA_W'(rd_word[FRAC_LSB +: FRAC_W]);
            FC_POST: host_rdata <= DATA_W'(rd_word[POST_LSB +: POST_W]);
            default: host_rdata <= '0;
         endcase
      end
   end

   logic commit_any;
   assign commit_any = host_we && (a_code == FC_COMMIT);

   // R4: live word holds while select is steady and nothing was committed
   a_r4_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(sel_sync) && !$past(commit_any)) |-> $stable(live_word));

   // R7: commit and reserved codes read back as zero
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (a_code >= FCODE_W'(4)) |=> (host_rdata == '0));

   // R6: readback of a narrow field never sets bits above its width
   a_r6_pre_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (a_code == FCODE_W'(0)) |=> ((host_rdata >> PRE_W) == '0));

endmodule

// File: tb/sim_divcfg_bank.sv
module sim_divcfg_bank;

   localparam int NS = 4;
   localparam int WW = 34;

   function automatic int fwid(input int f);
      case (f)
         0: return 2;
         1: return 7;
         2: return 18;
         default: return 7;
      endcase
   endfunction

   function automatic int defval(input int s, input int f);
      case (f)
         0: return s;
         1: return 20 + 10 * s;
         2: return 1000 * (s + 1);
         default: return 4 + s;
      endcase
   endfunction

   function automatic logic [NS*WW-1:0] mkdef();
      logic [NS*WW-1:0] v;
      v = '0;
      for (int s = 0; s < NS; s++)
         v[s*WW +: WW] = {2'(defval(s, 0)), 7'(defval(s, 1)),
                          18'(defval(s, 2)), 7'(defval(s, 3))};
      return v;
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  sel_pins = 2'd0;
   logic        host_we = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [17:0] host_wdata = '0;
   logic [17:0] host_rdata;
   logic [1:0]  div_pre;
   logic [6:0]  div_mint;
   logic [17:0] div_frac;
   logic [6:0]  div_post;
   logic [1:0]  sel_live;

   always #2 clk = ~clk;

   divcfg_bank #(.DEFAULTS(mkdef())) u0 (
      .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .div_pre(div_pre), .div_mint(div_mint), .div_frac(div_frac),
      .div_post(div_post), .sel_live(sel_live)
   );

   int n_chk = 0;
   int n_bad = 0;
   int exp_cm [NS][4];
   int exp_st [NS][4];
   int cur_sel = 0;
   int cycles = 0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_live(input string req);
      chk(req, int'(div_pre),  exp_cm[cur_sel][0]);
      chk(req, int'(div_mint), exp_cm[cur_sel][1]);
      chk(req, int'(div_frac), exp_cm[cur_sel][2]);
      chk(req, int'(div_post), exp_cm[cur_sel][3]);
      chk(req, int'(sel_live), cur_sel);
   endtask

   task automatic load_defaults();
      for (int s = 0; s < NS; s++)
         for (int f = 0; f < 4; f++) begin
            exp_cm[s][f] = defval(s, f);
            exp_st[s][f] = defval(s, f);
         end
      cur_sel = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; host_we = 1'b0; sel_pins = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      load_defaults();
      @(negedge clk);
   endtask

   task automatic wr(input int s, input int code, input int data);
      host_we = 1'b1;
      host_addr = {2'(s), 3'(code)};
      host_wdata = 18'(data);
      @(negedge clk);
      host_we = 1'b0;
      if (code < 4) exp_st[s][code] = data & ((1 << fwid(code)) - 1);
      else if (code == 4)
         for (int f = 0; f < 4; f++) exp_cm[s][f] = exp_st[s][f];
   endtask

   task automatic rd(input int s, input int code, input string req);
      host_addr = {2'(s), 3'(code)};
      @(negedge clk);
      chk(req, int'(host_rdata), (code < 4) ? exp_cm[s][code] : 0);
   endtask

   task automatic rd_all(input string req);
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < 8; c++) rd(s, c, req);
   endtask

   task automatic set_sel(input int s);
      int prev;
      prev = cur_sel;
      sel_pins = 2'(s);
      @(negedge clk);
      if (s != prev) chk("R5 early", int'(sel_live), prev);
      @(negedge clk);
      cur_sel = s;
      chk_live("R2/R5");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected finish", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R3: reset state
      chk("R3 rdata", int'(host_rdata), 0);
      chk_live("R3");
      rd_all("R3/R6/R7 defaults");
      for (int s = 0; s < NS; s++) set_sel(s);
      set_sel(2);

      // R1 R4 R7 R9: write each slot, commit, verify
      for (int s = 0; s < NS; s++) begin
         for (int f = 0; f < 4; f++) begin
            int v;
            v = (s * 37 + f * 11 + 1) % (1 << fwid(f));
            wr(s, f, v | (18'h3ffff & ~((1 << fwid(f)) - 1)));
            chk_live("R4 no early live");
            rd(s, f, "R4 no early readback");
         end
         for (int c = 5; c < 8; c++) wr(s, c, 18'h3ffff);
         wr(s, 4, 0);
         chk_live("R4 commit");
         rd_all("R1/R6/R9 after commit");
      end

      // R8: partial rewrite keeps the other staged fields
      wr(1, 1, 99);
      wr(1, 4, 0);
      rd_all("R8 partial commit");
      for (int s = 0; s < NS; s++) set_sel(s);

      // R3/R8: reset drops host values, reloads staging
      do_reset();
      chk_live("R3 after re-reset");
      rd_all("R3 defaults again");
      wr(0, 4, 0);
      rd_all("R8 commit after reset");
      set_sel(3);
      wr(3, 2, 18'h2aaaa);
      wr(3, 4, 0);
      chk_live("R4 live slot commit");
      set_sel(0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule